// File: doc/BRIEF.md
# Accumulator Processor Sequencing Controller

This block is the control unit of a small accumulator machine with four instructions: load, store, add, and branch when the accumulator is negative. It takes the two opcode bits of the instruction register, the sign bit of the accumulator, a memory handshake input and a reset input. From these it produces the register-transfer strobes that a separate datapath and memory use. Those strobes clear and increment the program counter, route addresses into the memory address register, request reads and writes, and move data among the buffer, instruction register and accumulator.

The controller is a sixteen-state Moore machine. Every instruction starts with a fetch sequence that waits on the memory handshake. A single decode state then makes a four-way jump on the opcode, and a short execute path for each instruction follows. Reset and the handshake pass through one synchronizing flip-flop each before the state logic sees them. Opcode and sign come from registers and are used directly. The strobes are held in a register loaded from the next state. Each strobe is therefore a clean function of the current state and changes only on a clock edge.

Top module: `accum_ctrl`

## Requirements
- R1: `rstIn` is seen through one flip-flop. When it has been high at one rising edge, the controller is in the reset state after the following edge, whatever state it was in. In the reset state only `pcClear` is high.
- R2: The reset state always goes to the first fetch state, which asserts `pcToMar` and `pcInc`. That state always goes to the address-wait fetch state, which asserts `memReq` and `memRead`.
- R3: The address-wait fetch state is held until the synchronized handshake is high. The data fetch state asserts `memReq`, `memRead` and `memToMbr`, and is held while the handshake is high. The instruction-latch state asserts `mbrToIr` and is held until the handshake is high, then goes to decode.
- R4: The decode state asserts no strobe and selects the next state from `opcode`, sampled in that state only: 2'b00 load, 2'b01 store, 2'b10 add, 2'b11 branch. `opcode` has no effect in any other state.
- R5: The load path is three states. The first asserts `irToMar`. The second asserts `memReq`, `memRead` and `memToMbr` and is held while the handshake is high. The third asserts `mbrToAc`. The path then returns to the first fetch state.
- R6: The store path is two states. The first asserts `irToMar` and `acToMbr`. The second asserts `memReq` with `memRead` low and is held while the handshake is high. The path then returns to the first fetch state.
- R7: The add path is the same as the load path except that its third state asserts `addToAc` instead of `mbrToAc`.
- R8: The branch test state asserts no strobe and reads `acSign` only there. With `acSign` 0 it returns to the first fetch state. With `acSign` 1 it passes through a state asserting `irToPc`, then returns to the first fetch state.
- R9: A change on `waitIn` alters the state one clock later than it would if the input were used directly.
- R10: All strobes are register outputs. Any strobe not listed for a state is 0. `memRead` is never high without `memReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstIn | input | 1 | Reset request, synchronized inside |
| waitIn | input | 1 | Memory handshake, synchronized inside |
| opcode | input | 2 | Instruction register bits 15:14 |
| acSign | input | 1 | Accumulator bit 15 |
| pcClear | output | 1 | Clear the program counter |
| pcInc | output | 1 | Increment the program counter |
| pcToMar | output | 1 | Program counter to memory address register |
| memReq | output | 1 | Memory request |
| memRead | output | 1 | 1 read, 0 write (only with memReq) |
| memToMbr | output | 1 | Memory data into buffer register |
| mbrToIr | output | 1 | Buffer register into instruction register |
| mbrToAc | output | 1 | Buffer register into accumulator |
| addToAc | output | 1 | Accumulator plus buffer into accumulator |
| irToMar | output | 1 | Instruction address field to memory address register |
| irToPc | output | 1 | Instruction address field to program counter |
| acToMbr | output | 1 | Accumulator into buffer register |

## Verification
The bench stretches each handshake wait over several cycles and checks the exact cycle in which each state is left. A controller that skips the input flip-flop leaves a wait state one cycle early. One that polls the wrong handshake level passes straight through or hangs. It walks all four opcodes and changes the opcode and sign bits while they should be ignored. A decoder that samples them in the wrong state then takes the wrong path or branches spuriously. A reset raised during a stalled store must land in the reset state exactly two edges later. A design without reset priority would instead stay in the store or drift into the fetch.

// File: rtl/accum_ctrl_pkg.sv
package accum_ctrl_pkg;

  localparam int STATE_W = 4;
  localparam int OP_W    = 2;

  typedef enum logic [STATE_W-1:0] {
    sRes  = 4'd0,
    sIf0  = 4'd1,
    sIf1  = 4'd2,
    sIf2  = 4'd3,
    sIf3  = 4'd4,
    sDec  = 4'd5,
    sLd0  = 4'd6,
    sLd1  = 4'd7,
    sLd2  = 4'd8,
    sSt0  = 4'd9,
    sSt1  = 4'd10,
    sAd0  = 4'd11,
    sAd1  = 4'd12,
    sAd2  = 4'd13,
    sBr0  = 4'd14,
    sBr1  = 4'd15
  } ctlState_e;

  localparam logic [OP_W-1:0] OP_LOAD  = 2'b00;
  localparam logic [OP_W-1:0] OP_STORE = 2'b01;
  localparam logic [OP_W-1:0] OP_ADD   = 2'b10;
  localparam logic [OP_W-1:0] OP_BRNEG = 2'b11;

  typedef struct packed {
    logic pcClear;
    logic pcInc;
    logic pcToMar;
    logic memReq;
    logic memRead;
    logic memToMbr;
    logic mbrToIr;
    logic mbrToAc;
    logic addToAc;
    logic irToMar;
    logic irToPc;
    logic acToMbr;
  } strobes_t;

endpackage

// File: rtl/accum_ctrl_sync.sv
module accum_ctrl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= dIn;

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk) chain[g] <= chain[g-1];
  end

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/accum_ctrl_next.sv
module accum_ctrl_next
  import accum_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rstSync,
  input  logic            waitSync,
  input  logic [OP_W-1:0] opcode,
  input  logic            acSign,
  output ctlState_e       stateNext
);

  ctlState_e stateQ;

  always_comb begin
    stateNext = stateQ;
    if (rstSync) begin
      stateNext = sRes;
    end else begin
      unique case (stateQ)
        sRes: stateNext = sIf0;
        sIf0: stateNext = sIf1;
        sIf1: stateNext = waitSync ? sIf2 : sIf1;
        sIf2: stateNext = waitSync ? sIf2 : sIf3;
        sIf3: stateNext = waitSync ? sDec : sIf3;
        sDec: begin
          unique case (opcode)
            OP_LOAD:  stateNext = sLd0;
            OP_STORE: stateNext = sSt0;
            OP_ADD:   stateNext = sAd0;
            default:  stateNext = sBr0;
          endcase
        end
        sLd0: stateNext = sLd1;
        sLd1: stateNext = waitSync ? sLd1 : sLd2;
        sLd2: stateNext = sIf0;
        sSt0: stateNext = sSt1;
        sSt1: stateNext = waitSync ? sSt1 : sIf0;
        sAd0: stateNext = sAd1;
        sAd1: stateNext = waitSync ? sAd1 : sAd2;
        sAd2: stateNext = sIf0;
        sBr0: stateNext = acSign ? sBr1 : sIf0;
        sBr1: stateNext = sIf0;
        default: stateNext = sRes;
      endcase
    end
  end

  always_ff @(posedge clk) stateQ <= stateNext;

endmodule

// File: rtl/accum_ctrl_strobes.sv
module accum_ctrl_strobes
  import accum_ctrl_pkg::*;
(
  input  logic      clk,
  input  ctlState_e stateNext,
  output strobes_t  strobes
);

  function automatic strobes_t decodeState(input ctlState_e st);
    strobes_t s;
    s = '0;
    unique case (st)
      sRes: s.pcClear = 1'b1;
      sIf0: begin s.pcToMar = 1'b1; s.pcInc = 1'b1; end
      sIf1: begin s.memReq = 1'b1; s.memRead = 1'b1; end
      sIf2, sLd1, sAd1: begin
        s.memReq = 1'b1; s.memRead = 1'b1; s.memToMbr = 1'b1;
      end
      sIf3: s.mbrToIr = 1'b1;
      sLd0, sAd0: s.irToMar = 1'b1;
      sLd2: s.mbrToAc = 1'b1;
      sSt0: begin s.irToMar = 1'b1; s.acToMbr = 1'b1; end
      sSt1: s.memReq = 1'b1;
      sAd2: s.addToAc = 1'b1;
      sBr1: s.irToPc = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

  always_ff @(posedge clk) strobes <= decodeState(stateNext);

endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic            clk,
  input  logic            rstIn,
  input  logic            waitIn,
  input  logic [OP_W-1:0] opcode,
  input  logic            acSign,
  output logic            pcClear,
  output logic            pcInc,
  output logic            pcToMar,
  output logic            memReq,
  output logic            memRead,
  output logic            memToMbr,
  output logic            mbrToIr,
  output logic            mbrToAc,
  output logic            addToAc,
  output logic            irToMar,
  output logic            irToPc,
  output logic            acToMbr
);

  logic      rstSync;
  logic      waitSync;
  ctlState_e stateNext;
  strobes_t  strobes;

  accum_ctrl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .dIn  ({rstIn, waitIn}),
    .qOut ({rstSync, waitSync})
  );

  accum_ctrl_next uNext (
    .clk       (clk),
    .rstSync   (rstSync),
    .waitSync  (waitSync),
    .opcode    (opcode),
    .acSign    (acSign),
    .stateNext (stateNext)
  );

  accum_ctrl_strobes uStrobes (
    .clk       (clk),
    .stateNext (stateNext),
    .strobes   (strobes)
  );

  assign pcClear  = strobes.pcClear;
  assign pcInc    = strobes.pcInc;
  assign pcToMar  = strobes.pcToMar;
  assign memReq   = strobes.memReq;
  assign memRead  = strobes.memRead;
  assign memToMbr = strobes.memToMbr;
  assign mbrToIr  = strobes.mbrToIr;
  assign mbrToAc  = strobes.mbrToAc;
  assign addToAc  = strobes.addToAc;
  assign irToMar  = strobes.irToMar;
  assign irToPc   = strobes.irToPc;
  assign acToMbr  = strobes.acToMbr;

endmodule

// File: rtl/accum_ctrl_chk.sv
module accum_ctrl_chk (
  input logic clk,
  input logic rstSync,
  input logic waitSync,
  input logic pcClear,
  input logic pcInc,
  input logic pcToMar,
  input logic memReq,
  input logic memRead,
  input logic memToMbr,
  input logic mbrToIr,
  input logic mbrToAc,
  input logic addToAc,
  input logic irToMar,
  input logic irToPc,
  input logic acToMbr
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rstSync) armed <= 1'b1;

  logic anyStrobe;
  assign anyStrobe = pcClear | pcInc | pcToMar | memReq | memRead | memToMbr |
                     mbrToIr | mbrToAc | addToAc | irToMar | irToPc | acToMbr;

  a_r1_reset_forces: assert property (@(posedge clk) disable iff (!armed)
    rstSync |=> (pcClear && !pcToMar && !memReq));

  a_r2_res_to_fetch: assert property (@(posedge clk) disable iff (!armed || rstSync)
    pcClear |=> (pcToMar && pcInc));

  a_r2_fetch_to_addr: assert property (@(posedge clk) disable iff (!armed || rstSync)
    (pcToMar && pcInc) |=> (memReq && memRead && !memToMbr));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!armed || rstSync)
    (memReq && memRead && !memToMbr && !waitSync) |=> (memReq && memRead && !memToMbr));

  a_r3_data_leave: assert property (@(posedge clk) disable iff (!armed || rstSync)
    (memToMbr && !waitSync) |=> (mbrToIr || mbrToAc || addToAc));

  a_r3_latch_to_decode: assert property (@(posedge clk) disable iff (!armed || rstSync)
    (mbrToIr && waitSync) |=> !anyStrobe);

  a_r6_store_done: assert property (@(posedge clk) disable iff (!armed || rstSync)
    (memReq && !memRead && !waitSync) |=> (pcToMar && pcInc));

  a_r8_branch_done: assert property (@(posedge clk) disable iff (!armed || rstSync)
    irToPc |=> (pcToMar && pcInc));

  a_r10_one_target: assert property (@(posedge clk) disable iff (!armed)
    $onehot0({pcClear, mbrToIr, mbrToAc, addToAc, irToPc}));

  a_r10_read_needs_req: assert property (@(posedge clk) disable iff (!armed)
    memRead |-> memReq);

endmodule

bind accum_ctrl accum_ctrl_chk chk (
  .clk      (clk),
  .rstSync  (rstSync),
  .waitSync (waitSync),
  .pcClear  (pcClear),
  .pcInc    (pcInc),
  .pcToMar  (pcToMar),
  .memReq   (memReq),
  .memRead  (memRead),
  .memToMbr (memToMbr),
  .mbrToIr  (mbrToIr),
  .mbrToAc  (mbrToAc),
  .addToAc  (addToAc),
  .irToMar  (irToMar),
  .irToPc   (irToPc),
  .acToMbr  (acToMbr)
);

// File: tb/accum_ctrl_test.sv
module accum_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 10000;

  // strobe vector order: pcClear pcInc pcToMar memReq memRead memToMbr
  //                      mbrToIr mbrToAc addToAc irToMar irToPc acToMbr
  localparam logic [11:0] V_RES = 12'b1000_0000_0000;
  localparam logic [11:0] V_IF0 = 12'b0110_0000_0000;
  localparam logic [11:0] V_IF1 = 12'b0001_1000_0000;
  localparam logic [11:0] V_IF2 = 12'b0001_1100_0000;
  localparam logic [11:0] V_IF3 = 12'b0000_0010_0000;
  localparam logic [11:0] V_DEC = 12'b0000_0000_0000;
  localparam logic [11:0] V_LD0 = 12'b0000_0000_0100;
  localparam logic [11:0] V_MRD = 12'b0001_1100_0000;
  localparam logic [11:0] V_LD2 = 12'b0000_0001_0000;
  localparam logic [11:0] V_ST0 = 12'b0000_0000_0101;
  localparam logic [11:0] V_ST1 = 12'b0001_0000_0000;
  localparam logic [11:0] V_AD2 = 12'b0000_0000_1000;
  localparam logic [11:0] V_BR0 = 12'b0000_0000_0000;
  localparam logic [11:0] V_BR1 = 12'b0000_0000_0010;

  logic clk = 1'b0;
  logic rstIn = 1'b1;
  logic waitIn = 1'b0;
  logic [1:0] opcode = 2'b00;
  logic acSign = 1'b0;
  logic pcClear, pcInc, pcToMar, memReq, memRead, memToMbr;
  logic mbrToIr, mbrToAc, addToAc, irToMar, irToPc, acToMbr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_ctrl uut (
    .clk(clk), .rstIn(rstIn), .waitIn(waitIn), .opcode(opcode), .acSign(acSign),
    .pcClear(pcClear), .pcInc(pcInc), .pcToMar(pcToMar), .memReq(memReq),
    .memRead(memRead), .memToMbr(memToMbr), .mbrToIr(mbrToIr), .mbrToAc(mbrToAc),
    .addToAc(addToAc), .irToMar(irToMar), .irToPc(irToPc), .acToMbr(acToMbr)
  );

  function automatic logic [11:0] outVec();
    return {pcClear, pcInc, pcToMar, memReq, memRead, memToMbr,
            mbrToIr, mbrToAc, addToAc, irToMar, irToPc, acToMbr};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expectVec(input logic [11:0] exp, input string tag);
    checks++;
    if (outVec() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, outVec(), exp);
    end
  endtask

  // fetch with stretched handshake; entered showing the first fetch state, waitIn low
  task automatic doFetch(input logic [1:0] op, input logic ac);
    opcode = op;
    acSign = ac;
    expectVec(V_IF0, "R2 first fetch state");
    step(); expectVec(V_IF1, "R2 address wait");
    step(); expectVec(V_IF1, "R3 address wait held");
    acSign = ~ac;
    step(); expectVec(V_IF1, "R3 address wait held 2");
    acSign = ac;
    waitIn = 1'b1;
    step(); expectVec(V_IF1, "R9 handshake delayed one clock");
    step(); expectVec(V_IF2, "R3 data fetch");
    step(); expectVec(V_IF2, "R3 data fetch held");
    waitIn = 1'b0;
    step(); expectVec(V_IF2, "R9 release delayed one clock");
    step(); expectVec(V_IF3, "R3 instruction latch");
    step(); expectVec(V_IF3, "R3 latch held");
    waitIn = 1'b1;
    step(); expectVec(V_IF3, "R9 latch release delayed");
    step(); expectVec(V_DEC, "R4 decode state quiet");
  endtask

  task automatic doLoadOrAdd(input bit isAdd);
    string tg;
    tg = isAdd ? "R7" : "R5";
    step(); expectVec(V_LD0, {tg, " address from instruction"});
    opcode = ~opcode;
    step(); expectVec(V_MRD, {tg, " operand read"});
    step(); expectVec(V_MRD, {tg, " operand read held"});
    waitIn = 1'b0;
    step(); expectVec(V_MRD, {tg, " operand read held until sync"});
    step(); expectVec(isAdd ? V_AD2 : V_LD2, {tg, " accumulator update"});
    step(); expectVec(V_IF0, {tg, " return to fetch"});
  endtask

  task automatic doStore(input bit withReset);
    step(); expectVec(V_ST0, "R6 address and data setup");
    opcode = 2'b10;
    step(); expectVec(V_ST1, "R6 write request");
    step(); expectVec(V_ST1, "R6 write held");
    if (withReset) begin
      rstIn = 1'b1;
      waitIn = 1'b0;
      step(); expectVec(V_ST1, "R1 reset delayed one clock");
      step(); expectVec(V_RES, "R1 reset overrides store");
      step(); expectVec(V_RES, "R1 reset held");
      rstIn = 1'b0;
      step(); expectVec(V_RES, "R1 release delayed one clock");
      step(); expectVec(V_IF0, "R2 fetch after reset");
    end else begin
      waitIn = 1'b0;
      step(); expectVec(V_ST1, "R6 write held until sync");
      step(); expectVec(V_IF0, "R6 return to fetch");
    end
  endtask

  task automatic doBranch(input logic ac);
    waitIn = 1'b0;
    step(); expectVec(V_BR0, "R8 branch test quiet");
    opcode = 2'b00;
    step();
    if (ac) begin
      expectVec(V_BR1, "R8 taken branch loads PC");
      step(); expectVec(V_IF0, "R8 return after taken");
    end else begin
      expectVec(V_IF0, "R8 not taken returns");
    end
  endtask

  initial begin
    step(); step(); step();
    expectVec(V_RES, "R1 reset state strobes");
    rstIn = 1'b0;
    step(); expectVec(V_RES, "R1 release delayed");
    step();
    doFetch(2'b00, 1'b1); doLoadOrAdd(1'b0);
    doFetch(2'b01, 1'b1); doStore(1'b0);
    doFetch(2'b10, 1'b1); doLoadOrAdd(1'b1);
    doFetch(2'b11, 1'b1); doBranch(1'b1);
    doFetch(2'b11, 1'b0); doBranch(1'b0);
    doFetch(2'b01, 1'b0); doStore(1'b1);
    doFetch(2'b00, 1'b0); doLoadOrAdd(1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule